// File: doc/BRIEF.md
# Five-Stage Pipeline Advance Sequencer

This block is the control skeleton of an in-order five-stage pipeline. The stages are fetch, decode/operand read, execute, memory access and writeback. Each stage holds one slot: a valid flag and an instruction tag. It carries no datapath values. On every clock edge each slot passes to the next stage, so a full pipeline retires one instruction per cycle.

An outside hazard detector drives a stall input. While it is high, the fetch and decode slots keep their contents and new issue is refused. Execute is loaded with an empty slot (a bubble). Memory and writeback keep moving, so older work drains out behind the held instruction. A writeback strobe and a wrapping retire counter let a user relate cycles, retired instructions and stall cycles.

Top module: `stage_seq`

## Requirements
- R1: While rst_ni is low, every stage valid bit is 0, every stage tag is 0 and the retire counter is 0.
- R2: With stall_i low, the slot in each stage moves one stage down on every clock edge (index 0 fetch, 1 decode, 2 execute, 3 memory, 4 writeback). An instruction issued with issue_vld_i high is in fetch after one edge and in writeback after five edges.
- R3: On an edge where stall_i is high, the fetch and decode slots keep their values, and issue_vld_i and issue_tag_i are ignored.
- R4: On an edge where stall_i is high, execute is loaded with a bubble (valid 0), whatever decode holds.
- R5: Memory and writeback take the slot of the stage before them on every edge, whether or not stall_i is high.
- R6: A stage whose valid bit is 0 shows tag 0. retire_o is high exactly when the writeback slot is valid.
- R7: The retire counter grows by one on each edge where writeback is valid, holds otherwise, and wraps modulo 2^CNT_W.
- R8: Take eight back-to-back instructions with a three-cycle stall applied while the fourth sits in decode. Writeback shows tags 1, 2, 3, then three bubbles, then tags 4 to 8. All eight retire 15 edges after the first issue edge: instructions + stall cycles + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| issue_vld_i | input | 1 | A new instruction is offered to fetch |
| issue_tag_i | input | TAG_W | Tag of the offered instruction |
| stall_i | input | 1 | Hold fetch and decode, and send a bubble into execute |
| stage_vld_o | output | 5 | Valid bit per stage, bit 0 = fetch, bit 4 = writeback |
| stage_tag_o | output | 5*TAG_W | Tag per stage, stage s at bits [s*TAG_W +: TAG_W] |
| retire_o | output | 1 | Writeback holds a valid instruction this cycle |
| retire_cnt_o | output | CNT_W | Wrapping count of retired instructions |

## Verification
Freezing the front on stall and retiring from writeback happen in the same cycle whenever a stall arrives behind valid work. The bench provokes this by sweeping every 6-bit stall pattern against a varied issue pattern. In each cycle it compares all five slots, the retire strobe and the counter with a stage model built from the requirements. A directed three-stall run checks the exact writeback order and the total retire cycle count.

// File: rtl/stage_seq_pkg.sv
package stage_seq_pkg;
  localparam int unsigned NUM_STAGES = 5;
  localparam int unsigned STG_IF = 0;
  localparam int unsigned STG_ID = 1;
  localparam int unsigned STG_EX = 2;
  localparam int unsigned STG_MA = 3;
  localparam int unsigned STG_WB = 4;
endpackage

// File: rtl/stage_slot.sv
module stage_slot #(
  parameter int unsigned TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             vld_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             vld_o,
  output logic [TAG_W-1:0] tag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      tag_o <= '0;
    end else if (load_i) begin
      vld_o <= vld_i;
      tag_o <= vld_i ? tag_i : '0;
    end
  end

  AST_IDLE_TAG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> (tag_o == '0)); // R6

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(vld_o) && $stable(tag_o))); // R3
endmodule

// File: rtl/retire_ctr.sv
module retire_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + ONE;
  end

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_o)); // R7

  AST_CNT_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> (cnt_o != $past(cnt_o))); // R7
endmodule

// File: rtl/stage_seq.sv
module stage_seq
  import stage_seq_pkg::*;
#(
  parameter int unsigned TAG_W = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        issue_vld_i,
  input  logic [TAG_W-1:0]            issue_tag_i,
  input  logic                        stall_i,
  output logic [NUM_STAGES-1:0]       stage_vld_o,
  output logic [NUM_STAGES*TAG_W-1:0] stage_tag_o,
  output logic                        retire_o,
  output logic [CNT_W-1:0]            retire_cnt_o
);
  logic             vld_q [NUM_STAGES];
  logic [TAG_W-1:0] tag_q [NUM_STAGES];

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    logic             load;
    logic             vld_in;
    logic [TAG_W-1:0] tag_in;

    if (s == STG_IF) begin : g_fetch
      assign load   = !stall_i;
      assign vld_in = issue_vld_i;
      assign tag_in = issue_tag_i;
    end else if (s == STG_ID) begin : g_decode
      assign load   = !stall_i;
      assign vld_in = vld_q[s-1];
      assign tag_in = tag_q[s-1];
    end else if (s == STG_EX) begin : g_exec
      // stall turns the decode hand-off into a bubble
      assign load   = 1'b1;
      assign vld_in = vld_q[s-1] && !stall_i;
      assign tag_in = tag_q[s-1];
    end else begin : g_drain
      assign load   = 1'b1;
      assign vld_in = vld_q[s-1];
      assign tag_in = tag_q[s-1];
    end

    stage_slot #(.TAG_W(TAG_W)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .vld_i  (vld_in),
      .tag_i  (tag_in),
      .vld_o  (vld_q[s]),
      .tag_o  (tag_q[s])
    );

    assign stage_vld_o[s]                = vld_q[s];
    assign stage_tag_o[s*TAG_W +: TAG_W] = tag_q[s];
  end

  assign retire_o = vld_q[STG_WB];

  retire_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (vld_q[STG_WB]),
    .cnt_o  (retire_cnt_o)
  );

  AST_FRONT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> (tag_q[STG_IF] == $past(tag_q[STG_IF]) && tag_q[STG_ID] == $past(tag_q[STG_ID])
                 && vld_q[STG_ID] == $past(vld_q[STG_ID]))); // R3

  AST_EX_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> !vld_q[STG_EX]); // R4

  AST_MA_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (vld_q[STG_MA] == $past(vld_q[STG_EX]) && tag_q[STG_MA] == $past(tag_q[STG_EX]))); // R5

  AST_WB_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (vld_q[STG_WB] == $past(vld_q[STG_MA]) && tag_q[STG_WB] == $past(tag_q[STG_MA]))); // R5

  AST_DECODE_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_i |=> (vld_q[STG_ID] == $past(vld_q[STG_IF]) && tag_q[STG_ID] == $past(tag_q[STG_IF]))); // R2
endmodule

// File: tb/stage_seq_bench.sv
`timescale 1ns/1ps
module stage_seq_bench;
  localparam int TW = 6;
  localparam int CW = 4;
  localparam int NS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iv = 1'b0;
  logic st = 1'b0;
  logic [TW-1:0] tg = '0;
  logic [NS-1:0] vo;
  logic [NS*TW-1:0] to;
  logic ret;
  logic [CW-1:0] cnt;

  int checks = 0;
  int errors = 0;

  logic          m_vld [NS];
  logic [TW-1:0] m_tag [NS];
  logic [CW-1:0] m_cnt;

  always #2.5 clk = ~clk;

  stage_seq #(.TAG_W(TW), .CNT_W(CW)) u_stage_seq (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .issue_vld_i  (iv),
    .issue_tag_i  (tg),
    .stall_i      (st),
    .stage_vld_o  (vo),
    .stage_tag_o  (to),
    .retire_o     (ret),
    .retire_cnt_o (cnt)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < NS; s++) begin
      m_vld[s] = 1'b0;
      m_tag[s] = '0;
    end
    m_cnt = '0;
  endtask

  task automatic chk_model(input string front_req);
    for (int s = 0; s < NS; s++) begin
      string r;
      r = (s < 2) ? front_req : ((s == 2) ? "R4" : "R5");
      chk(r, $sformatf("stage%0d valid", s), 32'(vo[s]), 32'(m_vld[s]));
      chk((m_vld[s] ? r : "R6"), $sformatf("stage%0d tag", s), 32'(to[s*TW +: TW]), 32'(m_tag[s]));
    end
    chk("R6", "retire strobe", 32'(ret), 32'(m_vld[4]));
    chk("R7", "retire count", 32'(cnt), 32'(m_cnt));
  endtask

  // called at a negedge: drive, advance model, wait one edge, compare
  task automatic step(input logic s_in, input logic v_in, input logic [TW-1:0] t_in);
    st = s_in; iv = v_in; tg = t_in;
    m_cnt = m_cnt + CW'(m_vld[4]);
    for (int s = NS-1; s >= 3; s--) begin
      m_vld[s] = m_vld[s-1];
      m_tag[s] = m_tag[s-1];
    end
    m_vld[2] = s_in ? 1'b0 : m_vld[1];
    m_tag[2] = s_in ? '0 : m_tag[1];
    if (!s_in) begin
      m_vld[1] = m_vld[0];
      m_tag[1] = m_tag[0];
      m_vld[0] = v_in;
      m_tag[0] = v_in ? t_in : '0;
    end
    @(posedge clk);
    @(negedge clk);
    chk_model(s_in ? "R3" : "R2");
  endtask

  task automatic chk_reset();
    for (int s = 0; s < NS; s++) begin
      chk("R1", $sformatf("stage%0d valid", s), 32'(vo[s]), 32'd0);
      chk("R1", $sformatf("stage%0d tag", s), 32'(to[s*TW +: TW]), 32'd0);
    end
    chk("R1", "retire count", 32'(cnt), 32'd0);
  endtask

  initial begin
    #(5.0 * 40000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    iv = 1'b1; tg = 6'h2a;
    repeat (3) @(negedge clk);
    chk_reset();
    rst_n = 1'b1;

    // R8 directed: 8 instructions, 3-cycle stall with tag 4 in decode
    for (int k = 1; k <= 16; k++) begin
      logic s_in, v_in;
      logic [TW-1:0] t_in;
      logic ev;
      logic [TW-1:0] et;
      if (k <= 5) begin s_in = 0; v_in = 1; t_in = TW'(k); end
      else if (k <= 8) begin s_in = 1; v_in = 1; t_in = '1; end
      else if (k <= 11) begin s_in = 0; v_in = 1; t_in = TW'(k - 3); end
      else begin s_in = 0; v_in = 0; t_in = '0; end
      step(s_in, v_in, t_in);
      if (k >= 5 && k <= 7) begin ev = 1; et = TW'(k - 4); end
      else if (k >= 11 && k <= 15) begin ev = 1; et = TW'(k - 7); end
      else begin ev = 0; et = '0; end
      chk("R8", $sformatf("writeback valid after edge %0d", k), 32'(vo[4]), 32'(ev));
      chk("R8", $sformatf("writeback tag after edge %0d", k), 32'(to[4*TW +: TW]), 32'(et));
    end
    chk("R8", "retired after 16 edges", 32'(cnt), 32'd8);

    // sweep all 6-bit stall patterns against a varied issue stream
    for (int p = 0; p < 64; p++) begin
      for (int c = 0; c < 12; c++) begin
        logic [5:0] pat;
        pat = 6'(p);
        step(pat[c % 6], ((c + p) % 3) != 0, TW'(p * 12 + c));
      end
    end

    // reset in mid-run (R1)
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_reset();
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    step(1'b0, 1'b0, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule